// File: doc/BRIEF.md
# Eight-Channel ADC Conversion Sequencer

This block is the digital controller placed around an 8-bit, eight-channel converter. Software reaches it through three byte-wide registers on a simple synchronous bus. Two of them are control registers and one is a read-only result. The control registers hold a channel number, an analog-input enable for that channel's pin, a reference-offset choice and a master enable.

Writing the start flag freezes the channel and offset into working copies and runs a fixed 35-cycle timeline. The timeline is an auto-zero/sample window, then a window that resolves the upper nibble, then a window that resolves the lower nibble. The converter model supplies an 8-bit code for the frozen channel. The sequencer takes the upper nibble when the second window closes and the lower nibble when the third one closes. It then loads the result register, pulses a done output and clears the start flag by itself, so software can poll that flag.

A new start issued mid-conversion drops the running conversion and begins again from sampling. Clearing the master enable powers the converter down. It also aborts any conversion and blocks every register access except writes that set the master enable again.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the master enable, analog-input enable, channel, offset and start flag are all 0, `adc_pwr` and `conv_done` are low, and `conv_ch` and `ref_ofs` are 0.
- R2: While enabled, a read of offset 8 returns {3'b001, ain, start flag, channel[2:0]} (bit 4 ain, bit 3 start flag, bits 2:0 channel). A read of offset 9 returns {enable, 1'b0, offset[1:0], 4'b1111}. Offset 0xA returns the result. Read data appears on `bus_rdata` one cycle after the read strobe.
- R3: While the master enable is 0, writes to offset 8 are ignored and reads of offsets 8, 9 and 0xA return 0xFF. A write to offset 9 changes only bit 7 and leaves the offset field untouched. Clearing the enable aborts a running conversion, so no done pulse follows.
- R4: A write to offset 8 with bit 3 set starts a conversion. The result register loads and `conv_done` is high for exactly one cycle, 35 clock edges after the edge that takes the start write. The result equals the code the converter model gives for the frozen channel.
- R5: The start flag (offset 8, bit 3) reads 1 while a conversion runs and reads 0 once it has completed.
- R6: A start written during a conversion abandons it. Only one done pulse follows, 35 edges after the second start, and it carries the code of the channel named by the second start.
- R7: Channel and offset writes made during a conversion leave `conv_ch`, `ref_ofs` and the result of that conversion unchanged. They are stored and read back, and they take effect at the next start.
- R8: `autozero` is high for the first 11 cycles after a start and low afterwards. The upper nibble of the result is taken at the 23rd edge after the start edge and the lower nibble at the 35th edge.
- R9: `ref_ofs` carries the 2-bit offset field frozen at start: 00 means 50 percent, 10 means 35 percent, 01 is reserved and 11 means no offset. `adc_pwr` follows the master enable.
- R10: While enabled, a read of any address other than 8, 9 or 0xA returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| adc_pwr | output | 1 | Converter power enable |
| ain_en | output | 1 | Analog-input enable for the selected pin |
| conv_ch | output | 3 | Channel frozen for the current conversion |
| ref_ofs | output | 2 | Reference offset frozen for the current conversion |
| autozero | output | 1 | Sample/auto-zero window active |
| conv_code | input | 8 | Code supplied by the converter model |
| conv_done | output | 1 | One-cycle pulse when the result loads |

## Verification
The done pulse and the result are due on the 35th edge after the edge that takes the start write. The upper nibble is taken on the 23rd edge and `autozero` falls on the 11th edge. Register reads return one edge after the strobe. The bench drives on falling edges and then counts falling edges from the start write to these exact offsets. It changes the model's code between the two nibble captures to pin down when each nibble is taken. It requires the done wait to measure exactly 35 and confirms that no done pulse appears 34 edges after a restart.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int DATA_W    = 8;
  localparam int OFS_CTRL0 = 8;
  localparam int OFS_CTRL1 = 9;
  localparam int OFS_RES   = 10;
  localparam logic [DATA_W-1:0] OFF_READ = 8'hFF;
  localparam logic [2:0] CTRL0_FIXED = 3'b001;
  localparam logic [3:0] CTRL1_LOWFIX = 4'b1111;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic              ain,
  output logic              start_p,
  output logic [CH_W-1:0]   act_ch,
  output logic [1:0]        act_ofs
);
  localparam logic [ADDR_W-1:0] A_C0  = ADDR_W'(OFS_CTRL0);
  localparam logic [ADDR_W-1:0] A_C1  = ADDR_W'(OFS_CTRL1);
  localparam logic [ADDR_W-1:0] A_RES = ADDR_W'(OFS_RES);

  logic [CH_W-1:0] ch_q;
  logic [1:0]      ofs_q;
  logic            wr_c0;
  logic [DATA_W-1:0] rd_mux;

  assign wr_c0   = wr && (addr == A_C0) && en;
  assign start_p = wr_c0 && wdata[3];

  always_comb begin
    if (addr == A_C0 || addr == A_C1 || addr == A_RES) begin
      if (!en)
        rd_mux = OFF_READ;
      else if (addr == A_C0)
        rd_mux = {CTRL0_FIXED, ain, busy, ch_q};
      else if (addr == A_C1)
        rd_mux = {en, 1'b0, ofs_q, CTRL1_LOWFIX};
      else
        rd_mux = result;
    end else begin
      rd_mux = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b0;
      ain     <= 1'b0;
      ch_q    <= '0;
      ofs_q   <= '0;
      act_ch  <= '0;
      act_ofs <= '0;
      rdata   <= '0;
    end else begin
      if (wr && addr == A_C1) begin
        en <= wdata[7];
        if (en) ofs_q <= wdata[5:4];
      end
      if (wr_c0) begin
        ain  <= wdata[4];
        ch_q <= wdata[CH_W-1:0];
      end
      if (start_p) begin
        act_ch  <= wdata[CH_W-1:0];
        act_ofs <= ofs_q;
      end
      if (rd) rdata <= rd_mux;
    end
  end

  AST_DISABLED_READ: assert property (@(posedge clk) disable iff (rst)
    (!en && rd && addr == A_RES && !wr) |=> rdata == OFF_READ) else $error("disabled read"); // R3
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int SAMP_CYC = 11,
  parameter int MSB_CYC  = 12,
  parameter int LSB_CYC  = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic autozero,
  output logic msb_end,
  output logic lsb_end
);
  localparam int TOTAL    = SAMP_CYC + MSB_CYC + LSB_CYC;
  localparam int CNT_W    = $clog2(TOTAL + 1);
  localparam int MSB_LAST = SAMP_CYC + MSB_CYC - 1;
  localparam int LSB_LAST = TOTAL - 1;

  logic [CNT_W-1:0] cnt;
  logic             run_ok;

  assign run_ok   = busy && !start && !abort;
  assign msb_end  = run_ok && (cnt == CNT_W'(MSB_LAST));
  assign lsb_end  = run_ok && (cnt == CNT_W'(LSB_LAST));
  assign autozero = busy && (cnt < CNT_W'(SAMP_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == CNT_W'(LSB_LAST)) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_START_SAMPLES: assert property (@(posedge clk) disable iff (rst)
    start |=> autozero) else $error("no sample window"); // R8
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (abort && !start) |=> !busy) else $error("abort ignored"); // R3
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt <= CNT_W'(LSB_LAST)) else $error("counter overrun"); // R4
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              msb_end,
  input  logic              lsb_end,
  input  logic [DATA_W-1:0] code,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  localparam int NIB_W = DATA_W / 2;

  logic [NIB_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= lsb_end;
      if (msb_end) hi_q <= code[DATA_W-1:NIB_W];
      if (lsb_end) result <= {hi_q, code[NIB_W-1:0]};
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done too long"); // R4
  AST_RES_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done) else $error("result moved without done"); // R4
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CH_W     = 3,
  parameter int SAMP_CYC = 11,
  parameter int MSB_CYC  = 12,
  parameter int LSB_CYC  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              adc_pwr,
  output logic              ain_en,
  output logic [CH_W-1:0]   conv_ch,
  output logic [1:0]        ref_ofs,
  output logic              autozero,
  input  logic [7:0]        conv_code,
  output logic              conv_done
);
  logic busy, start_p, en, msb_end, lsb_end;
  logic [DATA_W-1:0] result;

  adc_seq_regs #(.ADDR_W(ADDR_W), .CH_W(CH_W)) regs_i (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .busy(busy), .result(result), .rdata(bus_rdata),
    .en(en), .ain(ain_en), .start_p(start_p), .act_ch(conv_ch), .act_ofs(ref_ofs)
  );

  adc_seq_timer #(.SAMP_CYC(SAMP_CYC), .MSB_CYC(MSB_CYC), .LSB_CYC(LSB_CYC)) timer_i (
    .clk(clk), .rst(rst), .start(start_p), .abort(!en), .busy(busy),
    .autozero(autozero), .msb_end(msb_end), .lsb_end(lsb_end)
  );

  adc_seq_capture cap_i (
    .clk(clk), .rst(rst), .msb_end(msb_end), .lsb_end(lsb_end),
    .code(conv_code), .result(result), .done(conv_done)
  );

  assign adc_pwr = en;

  AST_CH_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !start_p) |=> ($stable(conv_ch) && $stable(ref_ofs))) else $error("settings moved"); // R7
  AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    conv_done |-> result[3:0] == $past(conv_code[3:0])) else $error("low nibble"); // R8
endmodule

// File: tb/adc_seq_tb.sv
module adc_seq_top_tb_top;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic adc_pwr, ain_en, autozero, conv_done;
  logic [2:0] conv_ch;
  logic [1:0] ref_ofs;
  logic [7:0] conv_code;
  logic [7:0] code_tab [8];
  logic       ovr_en = 1'b0;
  logic [7:0] ovr_val = '0;
  int n_run = 0, n_fail = 0, cyc = 0;
  logic [7:0] rv;
  int dn;

  always #(CLK_PER/2) clk = ~clk;
  assign conv_code = ovr_en ? ovr_val : code_tab[conv_ch];

  adc_seq_top dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_pwr(adc_pwr), .ain_en(ain_en),
    .conv_ch(conv_ch), .ref_ofs(ref_ofs), .autozero(autozero), .conv_code(conv_code),
    .conv_done(conv_done)
  );

  function automatic logic [7:0] c0v(logic ain, logic bsy, logic [2:0] ch);
    return {3'b001, ain, bsy, ch};
  endfunction
  function automatic logic [7:0] c1v(logic [1:0] ofs);
    return {1'b1, 1'b0, ofs, 4'hF};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!conv_done && n < 100) begin @(negedge clk); n++; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(2024));
    for (int i = 0; i < 8; i++) code_tab[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(!adc_pwr && !conv_done && conv_ch == 0 && ref_ofs == 0 && !ain_en, "R1 reset outputs",
        {adc_pwr, conv_done, ain_en, conv_ch, ref_ofs}, 0);
    rd(4'h8, rv); chk(rv == 8'hFF, "R3 disabled read ctrl0", rv, 8'hFF);
    rd(4'hA, rv); chk(rv == 8'hFF, "R3 disabled read result", rv, 8'hFF);

    // R3: start while disabled ignored, enable write drops offset
    wr(4'h8, 8'h3D);
    repeat (40) @(negedge clk);
    chk(!conv_done && !autozero, "R3 start while disabled", conv_done, 0);
    wr(4'h9, 8'hBF);
    rd(4'h9, rv); chk(rv == c1v(2'b00), "R3 offset kept on enabling write", rv, c1v(2'b00));
    rd(4'h8, rv); chk(rv == c0v(0, 0, 0), "R1 ctrl0 reset value", rv, c0v(0, 0, 0));
    chk(adc_pwr, "R9 power follows enable", adc_pwr, 1);
    rd(4'h3, rv); chk(rv == 8'h00, "R10 unmapped read", rv, 0);

    // R8 / R4 directed timeline with code change between nibble captures
    ovr_en = 1'b1; ovr_val = 8'hA5;
    wr(4'h8, c0v(1, 1, 3'd6));
    chk(autozero, "R8 autozero after start", autozero, 1);
    repeat (10) @(negedge clk);
    chk(autozero, "R8 autozero at cycle 10", autozero, 1);
    @(negedge clk);
    chk(!autozero, "R8 autozero low at cycle 11", autozero, 0);
    repeat (13) @(negedge clk);
    ovr_val = 8'h3C;
    repeat (10) @(negedge clk);
    chk(!conv_done, "R4 no done at 34", conv_done, 0);
    @(negedge clk);
    chk(conv_done, "R4 done at 35", conv_done, 1);
    @(negedge clk);
    chk(!conv_done, "R4 done one cycle", conv_done, 0);
    rd(4'hA, rv); chk(rv == 8'hAC, "R8 nibble capture order", rv, 8'hAC);
    ovr_en = 1'b0;

    // R5 polling
    wr(4'h8, c0v(0, 1, 3'd2));
    rd(4'h8, rv); chk(rv == c0v(0, 1, 3'd2), "R5 flag set while running", rv, c0v(0, 1, 3'd2));
    wait_done(dn);
    @(negedge clk);
    rd(4'h8, rv); chk(rv == c0v(0, 0, 3'd2), "R5 flag cleared", rv, c0v(0, 0, 3'd2));

    // R6 restart
    wr(4'h8, c0v(0, 1, 3'd1));
    repeat (20) @(negedge clk);
    wr(4'h8, c0v(0, 1, 3'd4));
    repeat (34) begin
      @(negedge clk);
      if (conv_done) chk(0, "R6 early done", 1, 0);
    end
    @(negedge clk);
    chk(conv_done, "R6 done 35 after restart", conv_done, 1);
    rd(4'hA, rv); chk(rv == code_tab[4], "R6 restart result", rv, code_tab[4]);

    // R7 mid-conversion writes
    wr(4'h9, c1v(2'b10));
    wr(4'h8, c0v(0, 1, 3'd2));
    wr(4'h8, c0v(1, 0, 3'd5));
    wr(4'h9, c1v(2'b11));
    chk(conv_ch == 3'd2 && ref_ofs == 2'b10, "R7 settings held", {conv_ch, ref_ofs}, {3'd2, 2'b10});
    wait_done(dn);
    @(negedge clk);
    rd(4'hA, rv); chk(rv == code_tab[2], "R7 result from frozen channel", rv, code_tab[2]);
    rd(4'h8, rv); chk(rv == c0v(1, 0, 3'd5), "R7 stored channel readback", rv, c0v(1, 0, 3'd5));

    // R3 disable aborts
    wr(4'h8, c0v(0, 1, 3'd7));
    repeat (5) @(negedge clk);
    wr(4'h9, 8'h00);
    dn = 0;
    repeat (45) begin @(negedge clk); if (conv_done) dn++; end
    chk(dn == 0, "R3 abort on disable", dn, 0);
    chk(!adc_pwr, "R9 power off", adc_pwr, 0);
    wr(4'h9, 8'h80);
    rd(4'h8, rv); chk(rv[3] == 1'b0, "R3 flag clear after abort", rv, 0);

    // random conversions
    for (int k = 0; k < 16; k++) begin
      logic [2:0] ch;
      logic [1:0] of;
      logic ai;
      ch = 3'($urandom); of = 2'($urandom); ai = 1'($urandom);
      code_tab[ch] = 8'($urandom);
      wr(4'h9, c1v(of));
      wr(4'h8, c0v(ai, 1, ch));
      chk(conv_ch == ch && ref_ofs == of && ain_en == ai, "R9 frozen outputs",
          {conv_ch, ref_ofs, ain_en}, {ch, of, ai});
      wait_done(dn);
      chk(dn == 35, "R4 latency", dn, 35);
      @(negedge clk);
      rd(4'hA, rv); chk(rv == code_tab[ch], "R4 random result", rv, code_tab[ch]);
      rd(4'h9, rv); chk(rv == c1v(of), "R2 ctrl1 readback", rv, c1v(of));
      rd(4'h8, rv); chk(rv == c0v(ai, 0, ch), "R2 ctrl0 readback", rv, c0v(ai, 0, ch));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule